// File: doc/BRIEF.md
# Status-Handshake SPI Slave Mailbox

This block lets an external host processor, acting as SPI master (mode 0), move whole buffers of 32-bit words to and from a local CPU. The local side owns one transmit buffer and one receive buffer. Each buffer has a single valid flag, so the local CPU loads the transmit buffer and arms it, or empties the receive buffer and releases it.

Every transaction starts when the select line goes low. The two sides first swap one status byte each. In that byte, bit 0 means "I can accept data" and bit 1 means "I hold data to send". The second byte in each direction is a word count. A side that is not allowed to send, or has nothing to send, gives zero. Full-duplex payload bytes follow until the larger of the two counts has been carried. The select line going high ends the transaction. If it goes high before the payload is complete, the transfer is dropped.

The serial inputs are sampled in the local clock domain. MOSI is captured on each rising SCK edge, and MISO moves to its next bit one local clock after that edge.

Top module: `mbox_spi_slave`

## Requirements
- R1: The first byte the slave shifts out after select falls is its status byte, MSB first. Bit 0 is 1 when the receive buffer is free (rx_valid low). Bit 1 equals tx_valid. Bits 7..2 are 0.
- R2: The second byte the slave sends is its transmit word count (tx_len, zero-extended). It is sent only when the master status byte had bit 0 set and tx_valid was high at select fall. Otherwise the byte is 0.
- R3: Payload words are sent most significant byte first and MSB first within each byte. A payload byte beyond the slave's own word count is sent as 0.
- R4: Master payload is stored only when the master status had bit 1 set and the receive buffer was free at select fall. Word i of the payload is then readable at rx_addr = i.
- R5: When a receive of a nonzero count completes, rx_valid is set and rx_len takes the count. rx_done_irq is high for exactly one clock.
- R6: When the slave has sent its full nonzero count, tx_valid is cleared.
- R7: If select rises before the last payload byte, the transfer is aborted. rx_valid, rx_done_irq and tx_valid are left unchanged.
- R8: A transaction that ends after the status byte, or where both counts are zero, changes no flag.
- R9: While tx_valid is high, tx_we and tx_go are ignored. The buffer contents and tx_len stay as they were.
- R10: While rx_valid is high, only rx_release clears it. The slave reports bit 0 = 0 and discards any master payload, so the stored words and rx_len are kept.
- R11: Only the low 6 bits of the master's count byte are used. The upper two bits are ignored.
- R12: After reset, tx_valid, rx_valid and rx_done_irq are 0, and spi_miso is 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from master, idle low |
| spi_mosi | input | 1 | Serial data from master |
| spi_cs_n | input | 1 | Active-low select, frames a transaction |
| spi_miso | output | 1 | Serial data to master, 0 when deselected |
| tx_we | input | 1 | Write one word into the transmit buffer |
| tx_addr | input | 6 | Transmit buffer word index |
| tx_wdata | input | 32 | Transmit buffer write data |
| tx_go | input | 1 | Arm the transmit buffer with tx_len words |
| tx_len | input | 6 | Word count taken by tx_go |
| tx_valid | output | 1 | Transmit buffer armed and not yet sent |
| rx_addr | input | 6 | Receive buffer word index |
| rx_rdata | output | 32 | Receive buffer read data (combinational) |
| rx_release | input | 1 | Local CPU frees the receive buffer |
| rx_valid | output | 1 | Receive buffer holds a complete payload |
| rx_len | output | 6 | Word count of the held payload |
| rx_done_irq | output | 1 | One-clock pulse on receive completion |

## Verification
The assertions assume the serial inputs are synchronous to clk and that each SCK level lasts at least two clocks. They also assume SCK is low when select falls and never rises in the same clock as the select edge. Under those conditions, the bit counter and the status load stay aligned to byte boundaries. The bench drives every serial input on the falling edge of clk, holds each SCK phase for two clocks, and leaves idle clocks around every select edge. It samples MISO just before each rising SCK edge, so the stimulus stays inside those assumptions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int STAT_RXRDY = 0;
    localparam int STAT_TXRDY = 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STATUS,
        PH_LEN,
        PH_PAY,
        PH_DONE
    } phase_t;

    function automatic logic [7:0] status_byte(input logic txrdy, input logic rxrdy);
        logic [7:0] s;
        s = 8'h00;
        s[STAT_TXRDY] = txrdy;
        s[STAT_RXRDY] = rxrdy;
        return s;
    endfunction

endpackage

// File: rtl/mbox_wordbuf.sv
module mbox_wordbuf #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/mbox_shifter.sv
module mbox_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       mosi_i,
    input  logic       cs_n_i,
    input  logic [7:0] status_i,
    input  logic [7:0] next_i,
    output logic       miso_o,
    output logic       start_o,
    output logic       end_o,
    output logic       byte_done_o,
    output logic [7:0] rx_byte_o
);
    typedef struct packed {
        logic       sck;
        logic       cs_n;
        logic [2:0] bit_cnt;
        logic [7:0] rx_sh;
        logic [7:0] tx_sh;
    } shf_t;

    shf_t q, d;
    logic rise;

    always_comb begin
        d         = q;
        d.sck     = sck_i;
        d.cs_n    = cs_n_i;
        start_o   = q.cs_n & ~cs_n_i;
        end_o     = ~q.cs_n & cs_n_i;
        rise      = sck_i & ~q.sck & ~cs_n_i & ~start_o;
        byte_done_o = rise & (q.bit_cnt == 3'd7);
        rx_byte_o = {q.rx_sh[6:0], mosi_i};
        if (start_o) begin
            d.bit_cnt = 3'd0;
            d.rx_sh   = 8'h00;
            d.tx_sh   = status_i;
        end else if (rise) begin
            d.rx_sh   = {q.rx_sh[6:0], mosi_i};
            d.bit_cnt = q.bit_cnt + 3'd1;
            if (q.bit_cnt == 3'd7) begin
                d.tx_sh = next_i;
            end else begin
                d.tx_sh = {q.tx_sh[6:0], 1'b0};
            end
        end
        miso_o = q.tx_sh[7] & ~cs_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sck: 1'b0, cs_n: 1'b1, bit_cnt: 3'd0, rx_sh: 8'h00, tx_sh: 8'h00};
        end else begin
            q <= d;
        end
    end

    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (q.bit_cnt == 3'd0)); // R1
    AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (q.tx_sh[7:2] == 6'd0)); // R1

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int LEN_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              end_i,
    input  logic              byte_done_i,
    input  logic [7:0]        rx_byte_i,
    output logic [7:0]        status_o,
    output logic [7:0]        next_o,
    input  logic              tx_we_i,
    input  logic              tx_go_i,
    input  logic [LEN_W-1:0]  tx_len_i,
    input  logic              rx_release_i,
    output logic              tx_mem_we_o,
    output logic [LEN_W-1:0]  tx_rd_addr_o,
    input  logic [DATA_W-1:0] tx_rd_data_i,
    output logic              rx_mem_we_o,
    output logic [LEN_W-1:0]  rx_wr_addr_o,
    output logic [DATA_W-1:0] rx_wr_data_o,
    output logic              tx_valid_o,
    output logic              rx_valid_o,
    output logic [LEN_W-1:0]  rx_len_o,
    output logic              rx_done_o
);
    localparam int BPW   = DATA_W / 8;
    localparam int KW    = $clog2(BPW);
    localparam int POS_W = LEN_W + KW;

    typedef struct packed {
        phase_t             phase;
        logic               adv_tx;
        logic               adv_rx;
        logic               m2s;
        logic               s2m;
        logic [LEN_W-1:0]   in_len;
        logic [LEN_W-1:0]   out_len;
        logic [LEN_W-1:0]   total;
        logic [POS_W-1:0]   pos;
        logic [DATA_W-1:0]  acc;
        logic               tx_valid;
        logic [LEN_W-1:0]   tx_len;
        logic               rx_valid;
        logic [LEN_W-1:0]   rx_len;
        logic               irq;
    } seq_t;

    seq_t q, d;
    logic [POS_W-1:0] np;
    logic [POS_W-1:0] end_pos;
    logic [7:0]       out_byte;

    function automatic logic [7:0] pick(input logic [DATA_W-1:0] w, input logic [KW-1:0] k);
        logic [7:0] r;
        r = 8'h00;
        for (int b = 0; b < BPW; b++) begin
            if (k == KW'(BPW - 1 - b)) begin
                r = w[b*8 +: 8];
            end
        end
        return r;
    endfunction

    always_comb begin
        d            = q;
        d.irq        = 1'b0;
        status_o     = status_byte(q.tx_valid, ~q.rx_valid);
        next_o       = 8'h00;
        tx_mem_we_o  = tx_we_i & ~q.tx_valid;
        rx_mem_we_o  = 1'b0;
        rx_wr_addr_o = q.pos[POS_W-1:KW];
        rx_wr_data_o = {q.acc[DATA_W-9:0], rx_byte_i};
        np           = (q.phase == PH_LEN) ? '0 : q.pos + 1'b1;
        end_pos      = {q.total, {KW{1'b0}}};
        tx_rd_addr_o = np[POS_W-1:KW];
        out_byte     = (np[POS_W-1:KW] < q.out_len) ? pick(tx_rd_data_i, np[KW-1:0]) : 8'h00;

        if (tx_go_i && !q.tx_valid) begin
            d.tx_valid = 1'b1;
            d.tx_len   = tx_len_i;
        end
        if (rx_release_i) begin
            d.rx_valid = 1'b0;
        end

        if (start_i) begin
            d.phase   = PH_STATUS;
            d.adv_tx  = q.tx_valid;
            d.adv_rx  = ~q.rx_valid;
            d.m2s     = 1'b0;
            d.s2m     = 1'b0;
            d.in_len  = '0;
            d.out_len = '0;
            d.total   = '0;
            d.pos     = '0;
        end else if (end_i) begin
            d.phase = PH_IDLE;
        end else if (byte_done_i) begin
            case (q.phase)
                PH_STATUS: begin
                    d.m2s = rx_byte_i[STAT_TXRDY] & q.adv_rx;
                    d.s2m = rx_byte_i[STAT_RXRDY] & q.adv_tx;
                    if (d.s2m) begin
                        d.out_len = q.tx_len;
                        next_o    = 8'(q.tx_len);
                    end
                    d.phase = PH_LEN;
                end
                PH_LEN: begin
                    d.in_len = q.m2s ? rx_byte_i[LEN_W-1:0] : '0;
                    d.total  = (d.in_len > q.out_len) ? d.in_len : q.out_len;
                    if (d.total == '0) begin
                        d.phase = PH_DONE;
                    end else begin
                        d.phase = PH_PAY;
                        next_o  = out_byte;
                    end
                end
                PH_PAY: begin
                    d.acc = {q.acc[DATA_W-9:0], rx_byte_i};
                    if ((q.pos[KW-1:0] == KW'(BPW - 1)) && (q.pos[POS_W-1:KW] < q.in_len)) begin
                        rx_mem_we_o = 1'b1;
                    end
                    d.pos = np;
                    if (np == end_pos) begin
                        d.phase = PH_DONE;
                        if (q.in_len != '0) begin
                            d.rx_valid = 1'b1;
                            d.rx_len   = q.in_len;
                            d.irq      = 1'b1;
                        end
                        if (q.out_len != '0) begin
                            d.tx_valid = 1'b0;
                        end
                    end else begin
                        next_o = out_byte;
                    end
                end
                default: begin
                    next_o = 8'h00;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign tx_valid_o = q.tx_valid;
    assign rx_valid_o = q.rx_valid;
    assign rx_len_o   = q.rx_len;
    assign rx_done_o  = q.irq;

    AST_RX_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mem_we_o |-> !q.rx_valid); // R10
    AST_RXV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rx_valid && !rx_release_i) |=> q.rx_valid); // R10
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |=> !q.irq); // R5
    AST_IRQ_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> (q.rx_valid && (q.rx_len != '0))); // R5
    AST_TXV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tx_valid && !(byte_done_i && q.phase == PH_PAY)) |=> q.tx_valid); // R9
    AST_TXLEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tx_valid && $past(q.tx_valid)) |-> $stable(q.tx_len)); // R9

endmodule

// File: rtl/mbox_spi_slave.sv
module mbox_spi_slave #(
    parameter int LEN_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    input  logic              tx_we,
    input  logic [LEN_W-1:0]  tx_addr,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_go,
    input  logic [LEN_W-1:0]  tx_len,
    output logic              tx_valid,
    input  logic [LEN_W-1:0]  rx_addr,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              rx_release,
    output logic              rx_valid,
    output logic [LEN_W-1:0]  rx_len,
    output logic              rx_done_irq
);
    logic              start_w, end_w, byte_done_w;
    logic [7:0]        rx_byte_w, status_w, next_w;
    logic              tx_mem_we_w, rx_mem_we_w;
    logic [LEN_W-1:0]  tx_rd_addr_w, rx_wr_addr_w;
    logic [DATA_W-1:0] tx_rd_data_w, rx_wr_data_w;

    mbox_shifter u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_i       (spi_sck),
        .mosi_i      (spi_mosi),
        .cs_n_i      (spi_cs_n),
        .status_i    (status_w),
        .next_i      (next_w),
        .miso_o      (spi_miso),
        .start_o     (start_w),
        .end_o       (end_w),
        .byte_done_o (byte_done_w),
        .rx_byte_o   (rx_byte_w)
    );

    mbox_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_w),
        .end_i        (end_w),
        .byte_done_i  (byte_done_w),
        .rx_byte_i    (rx_byte_w),
        .status_o     (status_w),
        .next_o       (next_w),
        .tx_we_i      (tx_we),
        .tx_go_i      (tx_go),
        .tx_len_i     (tx_len),
        .rx_release_i (rx_release),
        .tx_mem_we_o  (tx_mem_we_w),
        .tx_rd_addr_o (tx_rd_addr_w),
        .tx_rd_data_i (tx_rd_data_w),
        .rx_mem_we_o  (rx_mem_we_w),
        .rx_wr_addr_o (rx_wr_addr_w),
        .rx_wr_data_o (rx_wr_data_w),
        .tx_valid_o   (tx_valid),
        .rx_valid_o   (rx_valid),
        .rx_len_o     (rx_len),
        .rx_done_o    (rx_done_irq)
    );

    mbox_wordbuf #(.ADDR_W(LEN_W), .DATA_W(DATA_W)) u_txbuf (
        .clk     (clk),
        .we_i    (tx_mem_we_w),
        .waddr_i (tx_addr),
        .wdata_i (tx_wdata),
        .raddr_i (tx_rd_addr_w),
        .rdata_o (tx_rd_data_w)
    );

    mbox_wordbuf #(.ADDR_W(LEN_W), .DATA_W(DATA_W)) u_rxbuf (
        .clk     (clk),
        .we_i    (rx_mem_we_w),
        .waddr_i (rx_wr_addr_w),
        .wdata_i (rx_wr_data_w),
        .raddr_i (rx_addr),
        .rdata_o (rx_rdata)
    );

endmodule

// File: tb/sim_mbox_spi_slave.sv
module sim_mbox_spi_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
    logic        spi_miso;
    logic        tx_we = 1'b0, tx_go = 1'b0, rx_release = 1'b0;
    logic [5:0]  tx_addr = '0, tx_len = '0, rx_addr = '0;
    logic [31:0] tx_wdata = '0;
    logic        tx_valid, rx_valid, rx_done_irq;
    logic [31:0] rx_rdata;
    logic [5:0]  rx_len;

    int nchk = 0, nfail = 0, irq_cnt = 0;
    logic [7:0] got [0:255];

    always #2 clk = ~clk;

    mbox_spi_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .tx_we(tx_we), .tx_addr(tx_addr),
        .tx_wdata(tx_wdata), .tx_go(tx_go), .tx_len(tx_len), .tx_valid(tx_valid),
        .rx_addr(rx_addr), .rx_rdata(rx_rdata), .rx_release(rx_release),
        .rx_valid(rx_valid), .rx_len(rx_len), .rx_done_irq(rx_done_irq)
    );

    always @(posedge clk) if (rx_done_irq) irq_cnt <= irq_cnt + 1;

    typedef struct packed {
        logic       rel;
        logic [5:0] pre;
        logic [7:0] mst;
        logic [7:0] mlen;
        logic [7:0] nb;
        logic [7:0] est;
        logic [7:0] eslen;
        logic       erxv;
        logic       etxv;
        logic       eirq;
        logic [5:0] erxlen;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd0, 8'h00, 8'h00, 8'd1,  8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 6'd0},
        '{1'b0, 6'd3, 8'h01, 8'h00, 8'd14, 8'h03, 8'h03, 1'b0, 1'b0, 1'b0, 6'd0},
        '{1'b0, 6'd0, 8'h02, 8'h02, 8'd10, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1, 6'd2},
        '{1'b0, 6'd0, 8'h02, 8'h01, 8'd6,  8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 6'd2},
        '{1'b1, 6'd1, 8'h03, 8'h02, 8'd10, 8'h03, 8'h01, 1'b1, 1'b0, 1'b1, 6'd2},
        '{1'b1, 6'd2, 8'h03, 8'h02, 8'd7,  8'h03, 8'h02, 1'b0, 1'b1, 1'b0, 6'd0},
        '{1'b0, 6'd0, 8'h00, 8'h00, 8'd2,  8'h03, 8'h00, 1'b0, 1'b1, 1'b0, 6'd0},
        '{1'b0, 6'd0, 8'h03, 8'hC1, 8'd10, 8'h03, 8'h02, 1'b1, 1'b0, 1'b1, 6'd1},
        '{1'b1, 6'd0, 8'h00, 8'h00, 8'd2,  8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 6'd0}
    };

    function automatic logic [31:0] mpat(input int tag, input int i);
        return {8'hA5, 8'(tag), 8'h3C ^ 8'(i), 8'(i) + 8'h11};
    endfunction

    function automatic logic [31:0] tpat(input int tag, input int i);
        return {8'h5A, 8'(tag), 8'(i), 8'hC6 ^ 8'(i)};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = b[i];
            wait_clk(2);
            r[i] = spi_miso;
            spi_sck = 1'b1;
            wait_clk(2);
            spi_sck = 1'b0;
        end
        wait_clk(2);
    endtask

    task automatic xfer(input logic [7:0] mst, input logic [7:0] mlen, input int nb, input int mtag);
        logic [7:0] ob, ib;
        logic [31:0] w;
        spi_cs_n = 1'b0;
        wait_clk(4);
        for (int j = 0; j < nb; j++) begin
            if (j == 0) ob = mst;
            else if (j == 1) ob = mlen;
            else begin
                w  = mpat(mtag, (j - 2) / 4);
                ob = w[(3 - (j - 2) % 4) * 8 +: 8];
            end
            spi_byte(ob, ib);
            got[j] = ib;
        end
        spi_cs_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic preload(input int len, input int tag);
        for (int i = 0; i < len; i++) begin
            tx_we = 1'b1; tx_addr = 6'(i); tx_wdata = tpat(tag, i);
            wait_clk(1);
        end
        tx_we = 1'b0;
        tx_go = 1'b1; tx_len = 6'(len);
        wait_clk(1);
        tx_go = 1'b0;
        wait_clk(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
        finish_run();
    end

    initial begin
        int tx_tag, rx_tag, irq0;
        logic [31:0] w;
        logic [7:0]  eb;
        tx_tag = 0; rx_tag = 0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R12 reset state
        check(tx_valid == 1'b0, "R12 tx_valid", 32'(tx_valid), 0);
        check(rx_valid == 1'b0, "R12 rx_valid", 32'(rx_valid), 0);
        check(rx_done_irq == 1'b0, "R12 irq", 32'(rx_done_irq), 0);
        check(spi_miso == 1'b0, "R12 miso idle", 32'(spi_miso), 0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].rel) begin
                rx_release = 1'b1; wait_clk(1); rx_release = 1'b0; wait_clk(1);
            end
            if (VEC[v].pre != 0) begin
                preload(int'(VEC[v].pre), v);
                tx_tag = v;
            end
            irq0 = irq_cnt;
            xfer(VEC[v].mst, VEC[v].mlen, int'(VEC[v].nb), v);
            // R1 status byte
            check(got[0] == VEC[v].est, "R1 status", 32'(got[0]), 32'(VEC[v].est));
            // R2 length byte
            if (VEC[v].nb >= 2)
                check(got[1] == VEC[v].eslen, "R2 length", 32'(got[1]), 32'(VEC[v].eslen));
            // R3 payload, zero pad beyond own count
            for (int j = 2; j < int'(VEC[v].nb); j++) begin
                if ((j - 2) / 4 < int'(VEC[v].eslen)) begin
                    w  = tpat(tx_tag, (j - 2) / 4);
                    eb = w[(3 - (j - 2) % 4) * 8 +: 8];
                end else begin
                    eb = 8'h00;
                end
                check(got[j] == eb, "R3 payload byte", 32'(got[j]), 32'(eb));
            end
            // R5 R7 R8 R10 flags
            check(rx_valid == VEC[v].erxv, "R5/R7/R10 rx_valid", 32'(rx_valid), 32'(VEC[v].erxv));
            check(tx_valid == VEC[v].etxv, "R6/R7 tx_valid", 32'(tx_valid), 32'(VEC[v].etxv));
            check((irq_cnt - irq0) == int'(VEC[v].eirq), "R5 irq pulses",
                  32'(irq_cnt - irq0), 32'(VEC[v].eirq));
            if (VEC[v].eirq) rx_tag = v;
            // R4 R10 R11 stored words
            if (VEC[v].erxv) begin
                check(rx_len == VEC[v].erxlen, "R4/R11 rx_len", 32'(rx_len), 32'(VEC[v].erxlen));
                for (int i = 0; i < int'(VEC[v].erxlen); i++) begin
                    rx_addr = 6'(i);
                    wait_clk(1);
                    check(rx_rdata == mpat(rx_tag, i), "R4/R10 rx word", rx_rdata, mpat(rx_tag, i));
                end
            end
        end

        // R9: tx buffer locked while armed
        preload(2, 20);
        tx_we = 1'b1; tx_addr = 6'd0; tx_wdata = 32'hDEAD_BEEF;
        wait_clk(1);
        tx_we = 1'b0; tx_go = 1'b1; tx_len = 6'd5;
        wait_clk(1);
        tx_go = 1'b0;
        wait_clk(1);
        xfer(8'h01, 8'h00, 10, 21);
        check(got[1] == 8'h02, "R9 length kept", 32'(got[1]), 32'h2);
        w = tpat(20, 0);
        check({got[2], got[3], got[4], got[5]} == w, "R9 word kept",
              {got[2], got[3], got[4], got[5]}, w);
        check(tx_valid == 1'b0, "R6 tx_valid cleared", 32'(tx_valid), 0);

        // R12: reset clears armed state
        preload(1, 30);
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(2);
        check(tx_valid == 1'b0, "R12 tx_valid after reset", 32'(tx_valid), 0);
        check(spi_miso == 1'b0, "R12 miso after reset", 32'(spi_miso), 0);

        finish_run();
    end

endmodule